// File: doc/BRIEF.md
# Two-Line Secondary Interrupt Bank

This block gathers up to a parameterised number of interrupt sources, detects a chosen edge on each one, and latches the result into two separate status copies, one per host line. Each host line has its own mask and drives its own active-low interrupt output. Both lines share one trigger-select register, which sets which edges count for each source. A byte-wide register port reaches every register. The host can pick how status is acknowledged, either by reading it or by writing ones to it. It can also enable a one-deep buffer that holds an event arriving while the status bit is still set.

Source inputs pass through a two-stage synchroniser and then a history flop. A level change on a source therefore reaches status on the third rising clock edge after it is applied, and reaches the interrupt output on the fourth. A test-set register lets software raise status bits on both lines without any source activity.

Address map, with B = ceil(N/8) and E = ceil(2N/8). The line 0 status register starts at 0 and the line 0 mask at B. The line 1 status register starts at 2B and the line 1 mask at 3B. The test-set register is at 4B, the trigger-select register at 5B, and the control register at 5B+E. Multi-byte registers are little-endian. Unmapped addresses, and bit positions beyond the last source, read as zero.

Top module: `sih_bank`

## Requirements
- R1: After reset, both status registers read 0 and both mask registers read 1 at every implemented bit. Trigger-select and control read 0, and both interrupt outputs are high.
- R2: Trigger-select holds two bits per source, with source i at bits 2i+1 (rising edge enabled) and 2i (falling edge enabled), so byte k covers sources 4k to 4k+3. Only the enabled edge(s) of a synchronised source set its status bit.
- R3: A source whose two trigger bits are both 0 never sets status on either line, whatever its input does.
- R4: A detected edge sets the source's status bit on both lines, because both lines use the single shared trigger-select register.
- R5: With control bit 0 set (clear-on-read), a read of a status byte clears the bits it returns on that line only. Writes to status are ignored in this mode.
- R6: With control bit 0 clear (write-one-to-clear), writing 1 to a status bit clears it and writing 0 leaves it unchanged. Reads do not change status.
- R7: Each line's interrupt output is low exactly when that line's status AND NOT mask was non-zero on the previous clock edge, so it lags status by one cycle. Masked bits still latch into status.
- R8: With control bit 1 set, an event arriving while the status bit is already set is held. The first clear then leaves the bit set, and a second clear is needed. With control bit 1 clear, such an event is lost.
- R9: Writing 1s to the test-set register sets the matching status bits on both lines. The register itself reads 0.
- R10: If a clear and a new event for the same status bit happen in the same cycle, the bit stays set.
- R11: Registers follow the address map above, little-endian. Bits beyond 2N in trigger-select, bits beyond N in status and mask, and control bits 7:2 read as 0.
- R12: A source level change applied before a rising edge is reflected in status after the third rising edge, and in the interrupt output after the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | N | Asynchronous interrupt source levels |
| reg_addr_i | input | AW | Register byte address |
| reg_wr_i | input | 1 | Write strobe, taken at the rising edge |
| reg_rd_i | input | 1 | Read strobe; clear-on-read side effect takes place at the rising edge |
| reg_wdata_i | input | 8 | Write data byte |
| reg_rdata_o | output | 8 | Read data byte, combinational from address |
| irq_n_o | output | 2 | Active-low interrupt output, one per host line |

## Verification
The hardest case to reach is a clear that lands in the very cycle in which a new edge is recognised. The edge pulse exists for only one cycle, buried behind the synchroniser. The bench first presets the status bit through test-set. It then changes the source level on a falling edge, waits exactly two rising edges, and issues the write-one-to-clear so that it is taken on the third edge, the same one on which the detected edge is latched. A full sweep over every source and every trigger setting, with expected values computed from the bit-pair formula, covers the edge selection.

// File: rtl/sih_pkg.sv
package sih_pkg;
    localparam int CTRL_COR_BIT = 0;
    localparam int CTRL_BUF_BIT = 1;
    localparam int NUM_LINES    = 2;

    typedef enum logic [2:0] {
        RG_STAT,
        RG_MASK,
        RG_TSET,
        RG_EDGE,
        RG_CTRL,
        RG_NONE
    } region_e;
endpackage

// File: rtl/sih_edge.sv
module sih_edge #(
    parameter int N    = 24,
    parameter int SYNC = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   src_i,
    input  logic [2*N-1:0] trig_cfg_i,
    output logic [N-1:0]   evt_o
);
    logic [N-1:0] sync_q [SYNC];
    logic [N-1:0] hist_q;
    logic [N-1:0] rise_en;
    logic [N-1:0] fall_en;

    for (genvar s = 0; s < SYNC; s++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_q[s] <= '0;
            end else if (s == 0) begin
                sync_q[s] <= src_i;
            end else begin
                sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= sync_q[SYNC-1];
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            rise_en[i] = trig_cfg_i[2*i+1];
            fall_en[i] = trig_cfg_i[2*i];
        end
        evt_o = (sync_q[SYNC-1] & ~hist_q & rise_en) |
                (~sync_q[SYNC-1] & hist_q & fall_en);
    end
endmodule

// File: rtl/sih_line.sv
module sih_line #(
    parameter int N = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] evt_i,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         buf_en_i,
    input  logic [N-1:0] mask_wmask_i,
    input  logic [N-1:0] mask_wdata_i,
    output logic [N-1:0] st_o,
    output logic [N-1:0] mask_o,
    output logic         irq_n_o
);
    logic [N-1:0] st_q, st_n;
    logic [N-1:0] pend_q, pend_n;
    logic [N-1:0] mask_q;
    logic         irq_n_q;
    logic [N-1:0] hit;

    always_comb begin
        hit    = evt_i | set_i;
        st_n   = (st_q & ~clr_i) | hit | (clr_i & pend_q);
        pend_n = buf_en_i ? ((~clr_i & (pend_q | (st_q & hit))) |
                             (clr_i & pend_q & hit))
                          : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            pend_q  <= '0;
            mask_q  <= '1;
            irq_n_q <= 1'b1;
        end else begin
            st_q    <= st_n;
            pend_q  <= pend_n;
            mask_q  <= (mask_q & ~mask_wmask_i) | (mask_wdata_i & mask_wmask_i);
            irq_n_q <= ~|(st_q & ~mask_q);
        end
    end

    assign st_o    = st_q;
    assign mask_o  = mask_q;
    assign irq_n_o = irq_n_q;

    assert_irq_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (|(st_q & ~mask_q)) |=> !irq_n_o);
    assert_irq_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(st_q & ~mask_q)) |=> irq_n_o);
    assert_no_spurious_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q & ~$past(st_q)) & ~$past(evt_i | set_i)) == '0);
    assert_clear_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q & $past(clr_i & ~evt_i & ~set_i & ~pend_q)) == '0);
    assert_pend_needs_buf_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_q) |-> $past(buf_en_i));
endmodule

// File: rtl/sih_bank.sv
module sih_bank
    import sih_pkg::*;
#(
    parameter int N  = 24,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  src_i,
    input  logic [AW-1:0] reg_addr_i,
    input  logic          reg_wr_i,
    input  logic          reg_rd_i,
    input  logic [7:0]    reg_wdata_i,
    output logic [7:0]    reg_rdata_o,
    output logic [1:0]    irq_n_o
);
    localparam int B        = (N + 7) / 8;
    localparam int E        = (2 * N + 7) / 8;
    localparam int PW       = B * 8;
    localparam int EW       = E * 8;
    localparam int OFF_TSET = 4 * B;
    localparam int OFF_EDGE = 5 * B;
    localparam int OFF_CTRL = 5 * B + E;

    logic [2*N-1:0] trig_q;
    logic [1:0]     ctrl_q;
    logic [N-1:0]   evt;

    region_e reg_sel;
    int      line_sel;
    int      byte_sel;

    logic [N-1:0]  lane_n;
    logic [N-1:0]  wrep_n;
    logic [N-1:0]  set_v;
    logic [N-1:0]  st_w    [NUM_LINES];
    logic [N-1:0]  mask_w  [NUM_LINES];
    logic [N-1:0]  clr_w   [NUM_LINES];
    logic [N-1:0]  mwm_w   [NUM_LINES];
    logic [PW-1:0] pad_v;
    logic [EW-1:0] trig_pad;

    // address decode
    always_comb begin
        int a;
        a        = int'(reg_addr_i);
        reg_sel  = RG_NONE;
        line_sel = 0;
        byte_sel = 0;
        if (a < 4 * B) begin
            line_sel = a / (2 * B);
            reg_sel  = ((a % (2 * B)) < B) ? RG_STAT : RG_MASK;
            byte_sel = a % B;
        end else if (a < OFF_EDGE) begin
            reg_sel  = RG_TSET;
            byte_sel = a - OFF_TSET;
        end else if (a < OFF_CTRL) begin
            reg_sel  = RG_EDGE;
            byte_sel = a - OFF_EDGE;
        end else if (a == OFF_CTRL) begin
            reg_sel  = RG_CTRL;
        end
    end

    // byte lane of the selected byte, trimmed to N bits
    always_comb begin
        logic [PW-1:0] lp;
        logic [PW-1:0] wp;
        lp = '0;
        wp = '0;
        for (int b = 0; b < B; b++) begin
            wp[b*8 +: 8] = reg_wdata_i;
            if (byte_sel == b) lp[b*8 +: 8] = 8'hFF;
        end
        lane_n = lp[N-1:0];
        wrep_n = wp[N-1:0];
        set_v  = (reg_wr_i && reg_sel == RG_TSET) ? (lane_n & wrep_n) : '0;
    end

    // trigger-select and control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_q <= '0;
            ctrl_q <= '0;
        end else if (reg_wr_i) begin
            if (reg_sel == RG_EDGE) begin
                for (int b = 0; b < E; b++) begin
                    for (int k = 0; k < 8; k++) begin
                        if (byte_sel == b && (b * 8 + k) < 2 * N)
                            trig_q[b*8+k] <= reg_wdata_i[k];
                    end
                end
            end else if (reg_sel == RG_CTRL) begin
                ctrl_q <= reg_wdata_i[1:0];
            end
        end
    end

    sih_edge #(.N(N), .SYNC(2)) edge_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_i),
        .trig_cfg_i (trig_q),
        .evt_o      (evt)
    );

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        always_comb begin
            logic sel;
            sel = (line_sel == l);
            clr_w[l] = '0;
            if (sel && reg_sel == RG_STAT) begin
                if (ctrl_q[CTRL_COR_BIT]) begin
                    if (reg_rd_i) clr_w[l] = lane_n & st_w[l];
                end else if (reg_wr_i) begin
                    clr_w[l] = lane_n & wrep_n;
                end
            end
            mwm_w[l] = (sel && reg_sel == RG_MASK && reg_wr_i) ? lane_n : '0;
        end

        sih_line #(.N(N)) line_i (
            .clk          (clk),
            .rst_n        (rst_n),
            .evt_i        (evt),
            .set_i        (set_v),
            .clr_i        (clr_w[l]),
            .buf_en_i     (ctrl_q[CTRL_BUF_BIT]),
            .mask_wmask_i (mwm_w[l]),
            .mask_wdata_i (wrep_n),
            .st_o         (st_w[l]),
            .mask_o       (mask_w[l]),
            .irq_n_o      (irq_n_o[l])
        );
    end

    // read mux
    always_comb begin
        pad_v    = '0;
        trig_pad = '0;
        trig_pad[2*N-1:0] = trig_q;
        reg_rdata_o = 8'h00;
        unique case (reg_sel)
            RG_STAT: begin
                pad_v[N-1:0] = st_w[line_sel];
                reg_rdata_o  = pad_v[byte_sel*8 +: 8];
            end
            RG_MASK: begin
                pad_v[N-1:0] = mask_w[line_sel];
                reg_rdata_o  = pad_v[byte_sel*8 +: 8];
            end
            RG_EDGE: reg_rdata_o = trig_pad[byte_sel*8 +: 8];
            RG_CTRL: reg_rdata_o = {6'b0, ctrl_q};
            RG_TSET, RG_NONE: reg_rdata_o = 8'h00;
            default: reg_rdata_o = 8'h00;
        endcase
    end
endmodule

// File: tb/sih_bank_tb.sv
module sih_bank_tb_top;
    localparam int N = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [N-1:0] src = '0;
    logic [5:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [1:0] irq_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    sih_bank #(.N(N), .AW(6)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .reg_addr_i  (reg_addr),
        .reg_wr_i    (reg_wr),
        .reg_rd_i    (reg_rd),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .irq_n_o     (irq_n)
    );

    // map for N=10: stat0 0, mask0 2, stat1 4, mask1 6, tset 8, trig 10..12, ctrl 13
    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        reg_addr  = 6'(a);
        reg_wdata = 8'(d);
        reg_wr    = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        reg_addr = 6'(a);
        reg_rd   = 1'b1;
        #1 d = int'(reg_rdata);
        @(posedge clk);
        #1 reg_rd = 1'b0;
    endtask

    task automatic rd16(input int a, output int d);
        int lo, hi;
        rd(a, lo);
        rd(a + 1, hi);
        d = lo | (hi << 8);
    endtask

    task automatic set_trig(input logic [19:0] v);
        wr(10, v[7:0]);
        wr(11, v[15:8]);
        wr(12, {4'b0, v[19:16]});
    endtask

    task automatic src_set(input int i, input logic v);
        @(negedge clk);
        src[i] = v;
        repeat (4) @(posedge clk);
    endtask

    task automatic clear_all();
        wr(0, 8'hFF); wr(1, 8'hFF); wr(4, 8'hFF); wr(5, 8'hFF);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 irq_n", int'(irq_n), 3);
        rd16(0, v); chk("R1 stat0", v, 0);
        rd16(4, v); chk("R1 stat1", v, 0);
        rd16(2, v); chk("R1 mask0", v, 16'h03FF);
        rd16(6, v); chk("R1 mask1", v, 16'h03FF);
        rd(13, v);  chk("R1 ctrl", v, 0);
        rd(10, v);  chk("R1 trig", v, 0);

        // R11 readback and padding
        wr(12, 8'hFF); rd(12, v); chk("R11 trig pad", v, 8'h0F);
        wr(13, 8'hFF); rd(13, v); chk("R11 ctrl pad", v, 8'h03);
        wr(13, 0);     wr(12, 0);
        rd(3, v); chk("R11 mask0 pad byte", v, 8'h03);

        // R3 no-trigger sources never raise status
        @(negedge clk); src = '1; repeat (4) @(posedge clk);
        @(negedge clk); src = '0; repeat (4) @(posedge clk);
        rd16(0, v); chk("R3 stat0", v, 0);
        rd16(4, v); chk("R3 stat1", v, 0);
        @(negedge clk); chk("R3 irq_n", int'(irq_n), 3);

        // R2/R4 sweep: every source, every trigger setting
        for (int i = 0; i < N; i++) begin
            for (int m = 1; m < 4; m++) begin
                set_trig(20'(m) << (2 * i));
                src_set(i, 1'b1);
                rd16(0, v); chk("R2 rise line0", v, (m & 2) ? (1 << i) : 0);
                rd16(4, v); chk("R4 rise line1", v, (m & 2) ? (1 << i) : 0);
                clear_all();
                src_set(i, 1'b0);
                rd16(0, v); chk("R2 fall line0", v, (m & 1) ? (1 << i) : 0);
                rd16(4, v); chk("R4 fall line1", v, (m & 1) ? (1 << i) : 0);
                clear_all();
            end
        end

        // R7/R12 masking and latency
        set_trig(20'hAAAAA);
        wr(2, 8'hF7);
        @(negedge clk); src[3] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); chk("R12 irq not yet", int'(irq_n), 3);
        @(posedge clk); @(negedge clk);
        chk("R12 irq0 low after 4 edges", int'(irq_n), 2);
        rd(4, v); chk("R7 masked bit latched", v, 8'h08);
        wr(0, 8'h08);
        @(negedge clk); chk("R7 irq lags clear", int'(irq_n[0]), 0);
        @(posedge clk); @(negedge clk);
        chk("R7 irq0 released", int'(irq_n[0]), 1);
        wr(6, 8'hF7);
        @(posedge clk); @(negedge clk);
        chk("R7 irq1 after unmask", int'(irq_n[1]), 0);
        wr(4, 8'h08);
        wr(2, 8'hFF); wr(6, 8'hFF);
        src_set(3, 1'b0);

        // R5 clear-on-read
        wr(13, 1);
        src_set(5, 1'b1);
        rd(0, v); chk("R5 first read", v, 8'h20);
        rd(0, v); chk("R5 cleared by read", v, 0);
        wr(4, 8'hFF);
        rd(4, v); chk("R5 write ignored, line1 kept", v, 8'h20);
        rd(4, v); chk("R5 line1 cleared", v, 0);
        src_set(5, 1'b0);

        // R6 write-one-to-clear
        wr(13, 0);
        wr(8, 8'h01);
        rd(0, v); chk("R6 read keeps", v, 1);
        rd(0, v); chk("R6 read keeps again", v, 1);
        wr(0, 8'h00);
        rd(0, v); chk("R6 zero write keeps", v, 1);
        wr(0, 8'h01);
        rd(0, v); chk("R6 one write clears", v, 0);
        clear_all();

        // R8 buffering of a second event
        wr(13, 2);
        src_set(1, 1'b1); src_set(1, 1'b0); src_set(1, 1'b1);
        wr(0, 8'h02);
        rd(0, v); chk("R8 buffered re-set", v, 8'h02);
        wr(0, 8'h02);
        rd(0, v); chk("R8 second clear", v, 0);
        clear_all(); clear_all();
        wr(13, 0);
        src_set(1, 1'b0); src_set(1, 1'b1);
        src_set(1, 1'b0); src_set(1, 1'b1);
        wr(0, 8'h02);
        rd(0, v); chk("R8 no buffer, event lost", v, 0);
        clear_all();
        src_set(1, 1'b0);

        // R9 test-set
        wr(9, 8'h02);
        rd16(0, v); chk("R9 line0", v, 16'h0200);
        rd16(4, v); chk("R9 line1", v, 16'h0200);
        rd(9, v);   chk("R9 reads zero", v, 0);
        clear_all();

        // R10 clear and edge in the same cycle
        wr(8, 8'h10);
        @(negedge clk); src[4] = 1'b1;
        @(posedge clk); @(posedge clk);
        wr(0, 8'h10);
        rd(0, v); chk("R10 bit kept", v, 8'h10);
        rd(4, v); chk("R10 line1", v, 8'h10);
        wr(0, 8'h10);
        rd(0, v); chk("R10 plain clear", v, 0);
        clear_all();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule